// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog peripheral with a 32-bit register port. Software loads a 16-bit up-counter with a start value N, chooses a clock division ratio and sets an enable bit. The counter then advances once per divided tick. When it steps past 0xFFFF it wraps to zero, stops, latches a sticky overflow flag and raises a reset request for a fixed number of clocks. Periodic counter reloads ("pings") keep the request from firing. The time left is 65536 − N ticks.

Stray or runaway writes cannot change the block's behaviour. Every write must carry a key pattern in its upper data bits. The counter register and the control registers use different keys, and a write with a wrong key changes nothing. A short busy window follows each accepted write, and a request to change the enable bit inside that window is dropped. The block has two resets. The system reset, which the request itself normally causes, clears the timer but keeps the overflow flag, so software can later tell why the chip restarted. The power-on reset clears everything.

Top module: `keyed_wdog`

## Requirements
- R1: While `por_rst` is high, the counter, both control registers and the overflow flag are cleared, and `wdog_rst_req` is driven low.
- R2: A write to offset 0x0 loads data bits 15:0 into the counter only if data bits 31:16 equal 0x5A5A. Any other key leaves the counter unchanged.
- R3: A write to offset 0x4 or 0x8 takes effect only if data bits 31:8 equal 0xA5A5A5. Any other key leaves the register unchanged.
- R4: Control A bits 2:0 select the divide ratio: code 0 gives 1, 1 gives 4, 2 gives 16, 3 gives 32, 4 gives 64, 5 gives 128, 6 gives 1024 and 7 gives 4096. After the clock edge that accepts enable (control A bit 7) = 1 with the counter at N, the overflow occurs on exactly the (65536−N)·ratio-th following edge.
- R5: On overflow, the counter reads 0, the enable bit reads 0 and the overflow flag (control A bit 4) reads 1.
- R6: `wdog_rst_req` goes high on the clock after the overflow and stays high for exactly 16 clocks. The system reset does not shorten it.
- R7: Control A bit 5 reads 1 for two clocks after any accepted keyed write and is read-only. A keyed control A write that arrives while bit 5 is 1 leaves the enable bit unchanged.
- R8: The overflow flag survives `sys_rst`. It is cleared only by `por_rst` or by a keyed control A write with bit 4 = 0. Writing 1 to bit 4 never sets it.
- R9: Offset 0x0 reads the live counter value in bits 15:0 at any time, including while the timer runs.
- R10: Offset 0x8 is an 8-bit keyed register that reads back the last accepted payload in bits 7:0.
- R11: A keyed counter write while the timer runs reloads the counter and restarts the divider phase. The next overflow then follows R4, counted from the reload edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| por_rst | input | 1 | Power-on reset, synchronous, active high; clears all state |
| sys_rst | input | 1 | System reset, synchronous, active high; keeps the overflow flag and a running request |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data, including the key bits |
| rdata | output | 32 | Read data for `addr`, combinational |
| wdog_rst_req | output | 1 | Reset request, high for 16 clocks after an overflow |

## Verification
A write takes effect at the edge that samples it. Its busy bit reads 1 right after that edge and reads 0 two edges later. The enable write starts the count: overflow lands on edge (65536−N)·ratio after it, and the request is visible just after that same edge. The bench counts edges from the accepting edge and samples 1 ns after each rising edge, so every measured interval equals the required count exactly, with no tolerance. The live counter value is read at a known edge offset, and the request is timed as a run of exactly 16 high samples.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam logic [15:0] CNT_KEY = 16'h5A5A;
    localparam logic [23:0] CTL_KEY = 24'hA5A5A5;

    localparam logic [3:0] OFS_CNT  = 4'h0;
    localparam logic [3:0] OFS_CTLA = 4'h4;
    localparam logic [3:0] OFS_CTLB = 4'h8;

    // control A layout: bit positions are software-visible
    typedef struct packed {
        logic       en;     // 7
        logic       rsv6;   // 6
        logic       busy;   // 5
        logic       ovf;    // 4
        logic       rsv3;   // 3
        logic [2:0] sel;    // 2:0
    } ctla_t;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_CNT,
        TGT_CTLA,
        TGT_CTLB
    } tgt_e;

    function automatic tgt_e decode_tgt(input logic [3:0] a);
        case (a)
            OFS_CNT:  return TGT_CNT;
            OFS_CTLA: return TGT_CTLA;
            OFS_CTLB: return TGT_CTLB;
            default:  return TGT_NONE;
        endcase
    endfunction

    function automatic logic [12:0] div_ratio(input logic [2:0] s);
        case (s)
            3'd0:    return 13'd1;
            3'd1:    return 13'd4;
            3'd2:    return 13'd16;
            3'd3:    return 13'd32;
            3'd4:    return 13'd64;
            3'd5:    return 13'd128;
            3'd6:    return 13'd1024;
            default: return 13'd4096;
        endcase
    endfunction

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import keyed_wdog_pkg::*;
#(
    parameter int BUSY_LEN = 2,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              sys_rst,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              wrap,
    output ctla_t             ctla,
    output logic [7:0]        ctlb,
    output logic              cnt_ld,
    output logic [CNT_W-1:0]  cnt_ld_val
);

    localparam int BW = $clog2(BUSY_LEN + 1);

    tgt_e          tgt;
    logic          cnt_ok, ctla_ok, ctlb_ok;
    logic [BW-1:0] busy_cnt;
    logic          en_q, ovf_q;
    logic [2:0]    sel_q;
    logic [7:0]    ctlb_q;

    always_comb begin
        tgt     = decode_tgt(addr);
        cnt_ok  = wr_en && (tgt == TGT_CNT)  && (wdata[31:16] == CNT_KEY);
        ctla_ok = wr_en && (tgt == TGT_CTLA) && (wdata[31:8]  == CTL_KEY);
        ctlb_ok = wr_en && (tgt == TGT_CTLB) && (wdata[31:8]  == CTL_KEY);
    end

    always_ff @(posedge clk) begin
        if (por_rst) begin
            busy_cnt <= '0;
            en_q     <= 1'b0;
            ovf_q    <= 1'b0;
            sel_q    <= '0;
            ctlb_q   <= '0;
        end else if (sys_rst) begin
            busy_cnt <= '0;
            en_q     <= 1'b0;
            sel_q    <= '0;
            ctlb_q   <= '0;
        end else begin
            if (cnt_ok || ctla_ok || ctlb_ok)
                busy_cnt <= BW'(BUSY_LEN);
            else if (busy_cnt != '0)
                busy_cnt <= busy_cnt - 1'b1;

            if (wrap) begin
                en_q  <= 1'b0;
                ovf_q <= 1'b1;
            end else if (ctla_ok) begin
                if (busy_cnt == '0)
                    en_q <= wdata[7];
                sel_q <= wdata[2:0];
                ovf_q <= ovf_q & wdata[4];
            end

            if (ctlb_ok)
                ctlb_q <= wdata[7:0];
        end
    end

    always_comb begin
        ctla.en   = en_q;
        ctla.rsv6 = 1'b0;
        ctla.busy = (busy_cnt != '0);
        ctla.ovf  = ovf_q;
        ctla.rsv3 = 1'b0;
        ctla.sel  = sel_q;
    end

    assign ctlb       = ctlb_q;
    assign cnt_ld     = cnt_ok;
    assign cnt_ld_val = wdata[CNT_W-1:0];

endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler
    import keyed_wdog_pkg::*;
#(
    parameter int PRE_W = 12
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       restart,
    input  logic       en,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic [12:0]      limit;

    always_comb begin
        limit = div_ratio(sel) - 13'd1;
        tick  = en && (13'(pre_q) == limit);
    end

    always_ff @(posedge clk) begin
        if (clr || restart || !en || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             en,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt_q;

    assign wrap = en && tick && (&cnt_q) && !ld && !clr;
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (clr)
            cnt_q <= '0;
        else if (ld)
            cnt_q <= ld_val;
        else if (en && tick)
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic por_rst,
    input  logic trig,
    output logic req
);

    localparam int LW = $clog2(LEN + 1);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (por_rst)
            left_q <= '0;
        else if (trig)
            left_q <= LW'(LEN);
        else if (left_q != '0)
            left_q <= left_q - 1'b1;
    end

    assign req = (left_q != '0);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int PRE_W     = 12,
    parameter int BUSY_LEN  = 2,
    parameter int PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        por_rst,
    input  logic        sys_rst,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        wdog_rst_req
);

    ctla_t            ctla_q;
    logic [7:0]       ctlb_q;
    logic             cnt_ld;
    logic [CNT_W-1:0] cnt_ld_val;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             wrap;
    logic             tmr_clr;

    assign tmr_clr = por_rst || sys_rst;

    kwd_regs #(.BUSY_LEN(BUSY_LEN), .CNT_W(CNT_W)) regs_i (
        .clk        (clk),
        .por_rst    (por_rst),
        .sys_rst    (sys_rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .wrap       (wrap),
        .ctla       (ctla_q),
        .ctlb       (ctlb_q),
        .cnt_ld     (cnt_ld),
        .cnt_ld_val (cnt_ld_val)
    );

    kwd_prescaler #(.PRE_W(PRE_W)) pre_i (
        .clk     (clk),
        .clr     (tmr_clr),
        .restart (cnt_ld),
        .en      (ctla_q.en),
        .sel     (ctla_q.sel),
        .tick    (tick)
    );

    kwd_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk    (clk),
        .clr    (tmr_clr),
        .ld     (cnt_ld),
        .ld_val (cnt_ld_val),
        .en     (ctla_q.en),
        .tick   (tick),
        .cnt    (cnt_q),
        .wrap   (wrap)
    );

    kwd_pulse #(.LEN(PULSE_LEN)) pulse_i (
        .clk     (clk),
        .por_rst (por_rst),
        .trig    (wrap),
        .req     (wdog_rst_req)
    );

    always_comb begin
        case (decode_tgt(addr))
            TGT_CNT:  rdata = 32'(cnt_q);
            TGT_CTLA: rdata = {24'h0, ctla_q};
            TGT_CTLB: rdata = {24'h0, ctlb_q};
            default:  rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk (
    input logic        clk,
    input logic        por_rst,
    input logic        sys_rst,
    input logic        wr_en,
    input logic [3:0]  addr,
    input logic [31:0] wdata,
    input logic [15:0] cnt_q,
    input logic        en,
    input logic        busy,
    input logic        ovf,
    input logic        wrap,
    input logic        req
);

    // R1
    por_clear_chk: assert property (@(posedge clk) disable iff (sys_rst)
        por_rst |=> (cnt_q == 16'h0 && !ovf && !en && !req));

    // R2
    bad_cnt_key_chk: assert property (@(posedge clk) disable iff (por_rst)
        (wr_en && addr == 4'h0 && wdata[31:16] != 16'h5A5A && !en && !sys_rst)
        |=> $stable(cnt_q));

    // R5
    wrap_state_chk: assert property (@(posedge clk) disable iff (por_rst)
        wrap |=> (cnt_q == 16'h0 && !en && ovf));

    // R6
    wrap_req_chk: assert property (@(posedge clk) disable iff (por_rst)
        wrap |=> req);

    // R7
    busy_set_chk: assert property (@(posedge clk) disable iff (por_rst)
        (wr_en && addr == 4'h0 && wdata[31:16] == 16'h5A5A && !sys_rst) |=> busy);

    // R7
    busy_en_hold_chk: assert property (@(posedge clk) disable iff (por_rst)
        (wr_en && addr == 4'h4 && wdata[31:8] == 24'hA5A5A5 && busy && !wrap && !sys_rst)
        |=> $stable(en));

    // R8
    ovf_keep_chk: assert property (@(posedge clk) disable iff (por_rst)
        sys_rst |=> $stable(ovf));

endmodule

bind keyed_wdog keyed_wdog_chk chk_i (
    .clk     (clk),
    .por_rst (por_rst),
    .sys_rst (sys_rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .cnt_q   (cnt_q),
    .en      (ctla_q.en),
    .busy    (ctla_q.busy),
    .ovf     (ctla_q.ovf),
    .wrap    (wrap),
    .req     (wdog_rst_req)
);

// File: tb/keyed_wdog_tb_top.sv
`timescale 1ns/1ps
module keyed_wdog_tb_top;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        sys_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        wdog_rst_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    keyed_wdog dut_i (
        .clk          (clk),
        .por_rst      (por_rst),
        .sys_rst      (sys_rst),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .wdog_rst_req (wdog_rst_req)
    );

    // {sel, start value}
    localparam logic [18:0] VEC [0:7] = '{
        {3'd0, 16'hFFFC}, {3'd1, 16'hFFFE}, {3'd2, 16'hFFFD}, {3'd3, 16'hFFFF},
        {3'd4, 16'hFFFE}, {3'd5, 16'hFFFF}, {3'd6, 16'hFFFF}, {3'd7, 16'hFFFE}
    };

    function automatic int ratio_of(input logic [2:0] s);
        int r [8] = '{1, 4, 16, 32, 64, 128, 1024, 4096};
        return r[s];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic edges_to_req(output int n);
        n = 0;
        while (!wdog_rst_req && n < 20000) begin
            @(posedge clk);
            #1;
            n++;
        end
    endtask

    task automatic req_len(output int h);
        h = 1;
        forever begin
            @(posedge clk);
            #1;
            if (wdog_rst_req) h++;
            else break;
        end
    endtask

    initial begin
        int wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got %0d cycles expected under 150000", wd);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        int h;

        // R1: power-on state
        idle(3);
        por_rst = 1'b0;
        rd(4'h0, v); check("R1 cnt", v, 32'h0);
        rd(4'h4, v); check("R1 ctla", v, 32'h0);
        rd(4'h8, v); check("R1 ctlb", v, 32'h0);
        check("R1 req", 32'(wdog_rst_req), 32'h0);

        // R4 R5 R6: vector table
        foreach (VEC[i]) begin
            logic [2:0]  s  = VEC[i][18:16];
            logic [15:0] nv = VEC[i][15:0];
            wr(4'h4, {24'hA5A5A5, 5'b0, s});
            idle(3);
            wr(4'h0, {16'h5A5A, nv});
            idle(3);
            wr(4'h4, {24'hA5A5A5, 5'b10000, s});
            edges_to_req(n);
            check("R4 timeout", 32'(n), 32'((65536 - int'(nv)) * ratio_of(s)));
            rd(4'h0, v); check("R5 cnt zero", v, 32'h0);
            rd(4'h4, v); check("R5 en off ovf on", v & 32'h90, 32'h10);
            req_len(h);
            check("R6 req length", 32'(h), 32'd16);
        end

        // R8: flag survives system reset
        @(negedge clk); sys_rst = 1'b1;
        @(negedge clk); sys_rst = 1'b0;
        rd(4'h4, v); check("R8 ovf after sys_rst", v, 32'h10);
        wr(4'h4, 32'hA5A5A5_10); idle(3);
        rd(4'h4, v); check("R8 write 1 keeps ovf", v & 32'h10, 32'h10);
        wr(4'h4, 32'hA5A5A4_00); idle(3);
        rd(4'h4, v); check("R3 bad key keeps ovf", v & 32'h10, 32'h10);
        wr(4'h4, 32'hA5A5A5_00); idle(3);
        rd(4'h4, v); check("R8 keyed clear", v & 32'h10, 32'h0);

        // R2: counter key
        wr(4'h0, 32'h1234_00AB); idle(3);
        rd(4'h0, v); check("R2 bad key ignored", v, 32'h0);
        wr(4'h0, 32'h5A5A_1234); idle(3);
        rd(4'h0, v); check("R2 keyed load", v, 32'h1234);

        // R3 R10: control key and register B
        wr(4'h4, 32'hA5A5A4_87); idle(3);
        rd(4'h4, v); check("R3 bad key no enable", v, 32'h0);
        wr(4'h8, 32'h00A5A5_3C); idle(3);
        rd(4'h8, v); check("R3 ctlb bad key", v, 32'h0);
        wr(4'h8, 32'hA5A5A5_3C); idle(3);
        rd(4'h8, v); check("R10 ctlb readback", v, 32'h3C);

        // R7: busy window and dropped enable
        wr(4'h0, 32'h5A5A_0000);
        rd(4'h4, v); check("R7 busy edge 0", v & 32'h20, 32'h20);
        idle(1);
        rd(4'h4, v); check("R7 busy edge 1", v & 32'h20, 32'h20);
        idle(1);
        rd(4'h4, v); check("R7 busy clear", v & 32'h20, 32'h0);
        wr(4'h0, 32'h5A5A_0000);
        wr(4'h4, 32'hA5A5A5_82); idle(3);
        rd(4'h4, v); check("R7 enable dropped", v, 32'h02);

        // R9 R11: live read and ping with divide 16
        wr(4'h0, 32'h5A5A_FF00); idle(3);
        wr(4'h4, 32'hA5A5A5_82);
        idle(40);
        rd(4'h0, v); check("R9 live count", v, 32'hFF02);
        idle(7);
        wr(4'h0, 32'h5A5A_FFFE);
        edges_to_req(n);
        check("R11 ping timeout", 32'(n), 32'd32);

        // R1 R8: power-on reset clears flag and request
        @(negedge clk); por_rst = 1'b1;
        @(negedge clk); por_rst = 1'b0;
        rd(4'h4, v); check("R8 por clears ovf", v, 32'h0);
        check("R1 por drops req", 32'(wdog_rst_req), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule